// File: doc/BRIEF.md
# Quad-Lane Retimed Serializer

This block accepts four parallel transmit words, one per lane. Each lane is written from its own source clock, and these clocks need not be related to each other or to the reference clock. Every lane passes its words through a small dual-clock FIFO into a single reference clock domain. There, one shared divider sets the frame boundary for all lanes at once. On each frame boundary, every lane loads a word and shifts it out as 4-bit nibbles, one nibble per reference cycle.

Because all lanes are relaunched by the same divided reference, the four output nibble streams and the four forwarded lane clocks stay in step with each other, whatever the source clocks do. The serialization ratio is a build parameter. A ratio of 8 takes 32-bit words and a ratio of 4 takes 16-bit words. The sustained rate per lane is four lines at up to roughly 667 Mb/s each.

Each lane reports two sticky error conditions. An underflow means the lane had nothing to send at a frame boundary after it had started carrying traffic. An overflow means a write arrived while that lane's FIFO was full.

Top module: `quad_lane_serializer`

## Requirements
- R1: While rst_ni is low, every output is 0: lane_data_o, lane_clk_o, underflow_o and overflow_o.
- R2: A word loaded into a lane is emitted over RATIO consecutive reference cycles, one nibble per cycle. Nibble k occupies bits [4k+3:4k] of the word, so the least significant nibble goes first. Lane n drives bits [4n+3:4n] of lane_data_o and takes its words from bits [n*4*RATIO +: 4*RATIO] of wr_data_i.
- R3: Each frame lasts RATIO reference cycles. lane_clk_o is high during the first RATIO/2 nibbles of a frame and low during the rest. All four lane_clk_o bits are identical in every cycle, so the rising edges come exactly RATIO cycles apart.
- R4: Each lane delivers the words written to it in the same order, with none lost or duplicated, as long as its FIFO (4 entries) is never full at a write. The lanes do not affect each other.
- R5: A frame boundary that finds a lane's FIFO empty sends an all-zero frame on that lane. underflow_o for the lane is set on that boundary only if the lane has already loaded at least one word since reset. Zero frames that come before the first word leave the flag at 0.
- R6: A write to a lane whose FIFO is full is dropped, and that lane's overflow_o is set. This flag is synchronous to the lane's own wr_clk_i. The words that were accepted are still delivered in order.
- R7: underflow_o and overflow_o stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| ref_clk_i | input | 1 | Common reference (nibble) clock |
| wr_clk_i | input | 4 | Per-lane source clocks |
| wr_en_i | input | 4 | Per-lane write strobes, one per source clock |
| wr_data_i | input | 4*4*RATIO | Per-lane parallel words, lane n at [n*4*RATIO +: 4*RATIO] |
| lane_data_o | output | 16 | Four output nibbles, lane n at [4n+3:4n] |
| lane_clk_o | output | 4 | Forwarded lane clocks, all in phase |
| underflow_o | output | 4 | Sticky per-lane underflow, reference domain |
| overflow_o | output | 4 | Sticky per-lane overflow, source domain of that lane |

## Verification
The assertions assume that rst_ni is asserted long enough to reach every clock domain. They also assume that each wr_en_i changes only with its own wr_clk_i, so that the overflow checks in each source domain only ever see settled values. The bench drives each lane's strobe and data on the falling edge of that lane's clock, using four different source periods. It keeps bursts at four words or fewer, except in the one deliberate overflow run on lane 2. There, the model accepts any in-order subsequence of the written words, because the exact words that are dropped depend on the crossing latency.

// File: rtl/qls_pkg.sv
package qls_pkg;
  parameter int unsigned LANES = 4;
  parameter int unsigned NIB_W = 4;
endpackage

// File: rtl/qls_afifo.sv
module qls_afifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         rst_ni,
  input  logic         wr_clk_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         overflow_o,
  input  logic         rd_clk_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_XOR = {2'b11, {(PW-2){1'b0}}};

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rq1_q, rq2_q, wbin_nx;
  logic [PW-1:0] rbin_q, rgray_q, wq1_q, wq2_q, rbin_nx;
  logic          full, ovf_q;

  // write domain
  assign full    = (wgray_q == (rq2_q ^ FULL_XOR));
  assign wbin_nx = wbin_q + 1'b1;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rq1_q   <= '0;
      rq2_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      {rq2_q, rq1_q} <= {rq1_q, rgray_q};
      if (wr_en_i) begin
        if (full) begin
          ovf_q <= 1'b1;
        end else begin
          wbin_q  <= wbin_nx;
          wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
      end
    end
  end

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i && !full) mem_q[wbin_q[AW-1:0]] <= wr_data_i;
  end

  assign overflow_o = ovf_q;

  // read domain
  assign empty_o   = (rgray_q == wq2_q);
  assign rbin_nx   = rbin_q + 1'b1;
  assign rd_data_o = mem_q[rbin_q[AW-1:0]];

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wq1_q   <= '0;
      wq2_q   <= '0;
    end else begin
      {wq2_q, wq1_q} <= {wq1_q, wgray_q};
      if (rd_en_i && !empty_o) begin
        rbin_q  <= rbin_nx;
        rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/qls_ref_div.sv
module qls_ref_div #(
  parameter int unsigned RATIO = 8
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic fwd_clk_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] HALF = CW'(RATIO / 2);

  logic [CW-1:0] cnt_q, phase_q;

  // phase_q tracks the nibble index of the data register
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= LAST;
    end else begin
      phase_q <= cnt_q;
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o    = (cnt_q == '0);
  assign fwd_clk_o = (phase_q < HALF);
endmodule

// File: rtl/qls_lane_shift.sv
module qls_lane_shift #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              underflow_o
);
  logic [WORD_W-1:0] sreg_q;
  logic [NIB_W-1:0]  nib_q;
  logic              started_q, unf_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q    <= '0;
      nib_q     <= '0;
      started_q <= 1'b0;
      unf_q     <= 1'b0;
    end else if (load_i) begin
      if (valid_i) begin
        nib_q     <= word_i[NIB_W-1:0];
        sreg_q    <= word_i >> NIB_W;
        started_q <= 1'b1;
      end else begin
        nib_q  <= '0;
        sreg_q <= '0;
        if (started_q) unf_q <= 1'b1;
      end
    end else begin
      nib_q  <= sreg_q[NIB_W-1:0];
      sreg_q <= sreg_q >> NIB_W;
    end
  end

  assign nib_o       = nib_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/quad_lane_serializer.sv
module quad_lane_serializer
  import qls_pkg::*;
#(
  parameter int unsigned RATIO      = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned WORD_W    = NIB_W * RATIO
) (
  input  logic                    rst_ni,
  input  logic                    ref_clk_i,
  input  logic [LANES-1:0]        wr_clk_i,
  input  logic [LANES-1:0]        wr_en_i,
  input  logic [LANES*WORD_W-1:0] wr_data_i,
  output logic [LANES*NIB_W-1:0]  lane_data_o,
  output logic [LANES-1:0]        lane_clk_o,
  output logic [LANES-1:0]        underflow_o,
  output logic [LANES-1:0]        overflow_o
);
  logic tick, fwd_clk;

  qls_ref_div #(.RATIO(RATIO)) u_div (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .tick_o    (tick),
    .fwd_clk_o (fwd_clk)
  );

  assign lane_clk_o = {LANES{fwd_clk}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] rd_word;
    logic              empty;

    qls_afifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .rst_ni     (rst_ni),
      .wr_clk_i   (wr_clk_i[g]),
      .wr_en_i    (wr_en_i[g]),
      .wr_data_i  (wr_data_i[g*WORD_W +: WORD_W]),
      .overflow_o (overflow_o[g]),
      .rd_clk_i   (ref_clk_i),
      .rd_en_i    (tick),
      .rd_data_o  (rd_word),
      .empty_o    (empty)
    );

    qls_lane_shift #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_shift (
      .ref_clk_i   (ref_clk_i),
      .rst_ni      (rst_ni),
      .load_i      (tick),
      .valid_i     (!empty),
      .word_i      (rd_word),
      .nib_o       (lane_data_o[g*NIB_W +: NIB_W]),
      .underflow_o (underflow_o[g])
    );
  end
endmodule

// File: rtl/qls_chk.sv
module qls_chk #(
  parameter int unsigned RATIO = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned NIB_W = 4
) (
  input logic                   rst_ni,
  input logic                   ref_clk_i,
  input logic [LANES-1:0]       wr_clk_i,
  input logic [LANES*NIB_W-1:0] lane_data_o,
  input logic [LANES-1:0]       lane_clk_o,
  input logic [LANES-1:0]       underflow_o,
  input logic [LANES-1:0]       overflow_o
);
  logic        clk_d_q, seen_q;
  logic [15:0] gap_q, hi_q;
  logic        rise_s, fall_s;

  assign rise_s = lane_clk_o[0] && !clk_d_q;
  assign fall_s = !lane_clk_o[0] && clk_d_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d_q <= 1'b0;
      seen_q  <= 1'b0;
      gap_q   <= '0;
      hi_q    <= '0;
    end else begin
      clk_d_q <= lane_clk_o[0];
      if (rise_s) seen_q <= 1'b1;
      gap_q <= rise_s ? '0 : gap_q + 1'b1;
      hi_q  <= lane_clk_o[0] ? hi_q + 1'b1 : '0;
    end
  end

  // R3
  fwd_period_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (rise_s && seen_q) |-> (gap_q == 16'(RATIO - 1)));

  // R3
  fwd_high_len_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (fall_s && seen_q) |-> (hi_q == 16'(RATIO / 2)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R7
    underflow_sticky_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      underflow_o[g] |=> underflow_o[g]);

    // R5
    underflow_zero_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      $rose(underflow_o[g]) |-> (lane_data_o[g*NIB_W +: NIB_W] == '0));

    // R6
    overflow_sticky_chk: assert property (@(posedge wr_clk_i[g]) disable iff (!rst_ni)
      overflow_o[g] |=> overflow_o[g]);
  end
endmodule

bind quad_lane_serializer qls_chk #(.RATIO(RATIO), .LANES(qls_pkg::LANES), .NIB_W(qls_pkg::NIB_W)) u_qls_chk (
  .rst_ni      (rst_ni),
  .ref_clk_i   (ref_clk_i),
  .wr_clk_i    (wr_clk_i),
  .lane_data_o (lane_data_o),
  .lane_clk_o  (lane_clk_o),
  .underflow_o (underflow_o),
  .overflow_o  (overflow_o)
);

// File: tb/tb_quad_lane_serializer.sv
module tb_quad_lane_serializer;
  localparam int RATIO  = 8;
  localparam int LANES  = 4;
  localparam int NIB_W  = 4;
  localparam int WORD_W = NIB_W * RATIO;

  logic ref_clk = 1'b0;
  logic sc0 = 1'b0, sc1 = 1'b0, sc2 = 1'b0, sc3 = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]        src_clk;
  logic [LANES-1:0]        wr_en;
  logic [LANES*WORD_W-1:0] wr_data;
  logic [LANES*NIB_W-1:0]  lane_data;
  logic [LANES-1:0]        lane_clk, underflow, overflow;

  logic              wr_en_l   [LANES];
  logic [WORD_W-1:0] wr_data_l [LANES];

  always #10 ref_clk = ~ref_clk;  // 50 MHz reference
  always #12 sc0 = ~sc0;
  always #15 sc1 = ~sc1;
  always #9  sc2 = ~sc2;
  always #21 sc3 = ~sc3;
  assign src_clk = {sc3, sc2, sc1, sc0};

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      wr_en[l] = wr_en_l[l];
      wr_data[l*WORD_W +: WORD_W] = wr_data_l[l];
    end
  end

  quad_lane_serializer #(.RATIO(RATIO)) dut (
    .rst_ni      (rst_n),
    .ref_clk_i   (ref_clk),
    .wr_clk_i    (src_clk),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .lane_data_o (lane_data),
    .lane_clk_o  (lane_clk),
    .underflow_o (underflow),
    .overflow_o  (overflow)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [WORD_W-1:0] exp_q [LANES][$];
  logic [WORD_W-1:0] cmd_q [LANES][$];
  int  spacing   [LANES];
  bit  allow_drop[LANES];
  bit  started   [LANES];
  int  recv      [LANES];
  bit  mon_en = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // per-lane writers, driven on the falling edge of each source clock
  for (genvar g = 0; g < LANES; g++) begin : g_wr
    int wait_c = 0;
    initial begin
      wr_en_l[g] = 1'b0;
      wr_data_l[g] = '0;
    end
    always @(negedge src_clk[g]) begin
      wr_en_l[g] = 1'b0;
      if (!rst_n) begin
        wait_c = 0;
      end else if (wait_c > 0) begin
        wait_c--;
      end else if (cmd_q[g].size() > 0) begin
        wr_data_l[g] = cmd_q[g].pop_front();
        wr_en_l[g] = 1'b1;
        exp_q[g].push_back(wr_data_l[g]);
        wait_c = spacing[g];
      end
    end
  end

  // frame-level reference model, sampled on the falling reference edge
  logic [WORD_W-1:0] frame [LANES];
  int  pidx = 0;
  bit  collecting = 0;
  logic clk_prev = 1'b0;

  always @(negedge ref_clk) begin
    if (mon_en) begin
      chk(lane_clk == {LANES{lane_clk[0]}}, "R3", "lane clocks in phase", 64'(lane_clk), {60'd0, {LANES{lane_clk[0]}}});
      if (lane_clk[0] && !clk_prev) begin
        pidx = 0;
        collecting = 1;
      end
      if (collecting && pidx < RATIO) begin
        chk(lane_clk[0] == (pidx < RATIO / 2), "R3", "forwarded clock level", 64'(lane_clk[0]), 64'(pidx < RATIO / 2));
        for (int l = 0; l < LANES; l++) frame[l][NIB_W*pidx +: NIB_W] = lane_data[l*NIB_W +: NIB_W];
        if (pidx == RATIO - 1) begin
          for (int l = 0; l < LANES; l++) begin
            if (frame[l] != '0) begin
              started[l] = 1;
              if (allow_drop[l]) begin
                while (exp_q[l].size() > 0 && exp_q[l][0] != frame[l]) void'(exp_q[l].pop_front());
                chk(exp_q[l].size() > 0, "R6", "received word is an in-order written word", 64'(frame[l]), 64'(frame[l]));
                if (exp_q[l].size() > 0) void'(exp_q[l].pop_front());
                recv[l]++;
              end else if (exp_q[l].size() == 0) begin
                chk(0, "R4", "unexpected word", 64'(frame[l]), 64'd0);
              end else begin
                chk(frame[l] == exp_q[l][0], "R2", "serialized word", 64'(frame[l]), 64'(exp_q[l][0]));
                void'(exp_q[l].pop_front());
              end
            end else begin
              chk(underflow[l] == started[l], "R5", "underflow on zero frame", 64'(underflow[l]), 64'(started[l]));
            end
          end
        end
        pidx++;
      end
      clk_prev = lane_clk[0];
    end
  end

  int cyc = 0;
  always @(negedge ref_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_model();
    for (int l = 0; l < LANES; l++) begin
      exp_q[l].delete();
      cmd_q[l].delete();
      started[l] = 0;
      recv[l] = 0;
      allow_drop[l] = 0;
    end
    collecting = 0;
    pidx = 0;
    clk_prev = 1'b0;
  endtask

  task automatic push_words(int l, int n, int sp);
    spacing[l] = sp;
    for (int k = 0; k < n; k++) begin
      logic [WORD_W-1:0] w;
      w = WORD_W'($urandom);
      w[WORD_W-1] = 1'b1;
      cmd_q[l].push_back(w);
    end
  endtask

  task automatic drain(string req);
    int k;
    bit idle;
    idle = 0;
    for (k = 0; k < 4000 && !idle; k++) begin
      @(negedge ref_clk);
      idle = 1;
      for (int l = 0; l < LANES; l++)
        if (cmd_q[l].size() > 0 || exp_q[l].size() > 0) idle = 0;
    end
    chk(idle, req, "all written words delivered", 64'(k), 64'd4000);
  endtask

  initial begin
    clear_model();
    for (int l = 0; l < LANES; l++) spacing[l] = 0;
    rst_n = 0;
    repeat (5) @(negedge ref_clk);
    chk(lane_data == '0, "R1", "data in reset", 64'(lane_data), 64'd0);
    chk(lane_clk == '0, "R1", "clocks in reset", 64'(lane_clk), 64'd0);
    chk(underflow == '0, "R1", "underflow in reset", 64'(underflow), 64'd0);
    chk(overflow == '0, "R1", "overflow in reset", 64'(overflow), 64'd0);
    rst_n = 1;
    mon_en = 1;
    repeat (40) @(negedge ref_clk);
    chk(underflow == '0, "R5", "no underflow before first word", 64'(underflow), 64'd0);

    // independent lanes, differing rates
    push_words(0, 6, 12);
    push_words(1, 6, 10);
    push_words(2, 4, 0);
    push_words(3, 8, 4);
    drain("R4");
    repeat (3 * RATIO) @(negedge ref_clk);
    chk(overflow == '0, "R6", "no overflow without full FIFO", 64'(overflow), 64'd0);
    chk(underflow == '1, "R5", "underflow after lanes ran dry", 64'(underflow), 64'hf);

    // deliberate overflow on lane 2
    allow_drop[2] = 1;
    recv[2] = 0;
    push_words(2, 10, 0);
    repeat (400) @(negedge ref_clk);
    chk(overflow == 4'b0100, "R6", "overflow on lane 2 only", 64'(overflow), 64'h4);
    chk(recv[2] >= 4 && recv[2] < 10, "R6", "accepted word count", 64'(recv[2]), 64'd4);

    repeat (50) @(negedge ref_clk);
    chk(underflow == '1, "R7", "underflow held", 64'(underflow), 64'hf);
    chk(overflow[2] == 1'b1, "R7", "overflow held", 64'(overflow[2]), 64'd1);

    mon_en = 0;
    rst_n = 0;
    repeat (3) @(negedge ref_clk);
    chk(underflow == '0 && overflow == '0, "R7", "flags cleared by reset", 64'({underflow, overflow}), 64'd0);
    clear_model();
    rst_n = 1;
    mon_en = 1;

    // short bursts on every lane after reset
    for (int l = 0; l < LANES; l++) push_words(l, 3, 0);
    drain("R2");
    repeat (3 * RATIO) @(negedge ref_clk);
    chk(overflow == '0, "R6", "no overflow on short bursts", 64'(overflow), 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule